// File: doc/BRIEF.md
# Single-Word Stream Transmitter

This block hands one data word at a time from a plain user interface to a downstream stream consumer. The user places a word on its data input and pulses a send strobe for one cycle. The block captures the word, presents it on the stream output with valid and last both high, and keeps it there until the consumer takes it. Every transfer is therefore a packet of exactly one beat.

The stream side follows the usual valid/ready rules. A beat is accepted on a rising clock edge where valid and ready are both high. While ready is low, the consumer applies back-pressure: data, valid and last stay frozen. Valid never waits for ready, so a consumer may legally hold ready low until it sees valid. The block returns a one-cycle done pulse to the user one cycle after each accepting edge. A send strobe is taken only when the output stage is free, or is being freed on the same edge. Any other strobe is dropped. The block stores at most one word.

Top module: `sst_word_tx`

## Requirements
- R1: With the active-low reset low at a rising edge, after that edge valid, last and done are 0 and the data output is all zeros.
- R2: A send strobe seen at a rising edge while valid is low loads the user word onto the data output, and valid is 1 after that edge.
- R3: While valid is 1 and ready is 0, data, valid and last keep their values from edge to edge.
- R4: At an edge where valid and ready are both 1 and send is 0, valid and last go to 0 after that edge.
- R5: done is 1 for exactly the cycle that follows each accepting edge, and is 0 at all other times.
- R6: A send strobe at an edge where valid is 1 and ready is 0 is dropped. The held data keeps its value, and no extra done pulse occurs later.
- R7: A send strobe at an accepting edge loads the new word, and valid stays 1. The done pulse for the accepted word still occurs.
- R8: Valid rises after a send even when ready has been 0 throughout.
- R9: last always equals valid, so every packet is one beat long.
- R10: Ready held at 1 while valid is 0 produces neither valid nor done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| usr_word | input | DW (32) | Word to transmit, sampled with usr_send |
| usr_send | input | 1 | One-cycle request to transmit usr_word |
| usr_done | output | 1 | One-cycle pulse after the word is accepted |
| st_tdata | output | DW (32) | Stream data |
| st_tvalid | output | 1 | Stream valid |
| st_tlast | output | 1 | Stream end of packet, high with every beat |
| st_tready | input | 1 | Stream ready from the consumer |

## Verification
The bench sweeps the back-pressure length from zero to six stalled cycles. It pairs each length with several word values computed from the loop indices, so a data path that stuck or swapped bits would show up. Half of the sweep fires extra send strobes during the stall, which separates a design that drops them from one that overwrites the held word. Separate scenarios cover the following cases:
- a strobe that coincides with acceptance, which tells a seamless reload apart from a lost word;
- ready held high while idle, which tells a correct idle state from a spurious beat;
- reset during a stalled transfer.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int SST_DW_DEFAULT = 32;

  typedef enum logic {
    SST_IDLE = 1'b0,
    SST_BUSY = 1'b1
  } sst_state_e;
endpackage

// File: rtl/sst_ctrl.sv
module sst_ctrl
  import sst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic send,
  input  logic ready,
  output logic load,
  output logic fire,
  output logic valid,
  output logic last
);
  sst_state_e state_q;
  logic       last_q;

  // A beat leaves on an edge where the stage is busy and the consumer is ready.
  assign fire  = (state_q == SST_BUSY) && ready;
  // The stage takes a new word when it is empty or is emptying on this edge.
  assign load  = send && ((state_q == SST_IDLE) || fire);
  assign valid = (state_q == SST_BUSY);
  assign last  = last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SST_IDLE;
      last_q  <= 1'b0;
    end else if (load) begin
      state_q <= SST_BUSY;
      last_q  <= 1'b1;
    end else if (fire) begin
      state_q <= SST_IDLE;
      last_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/sst_hold.sv
module sst_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    word_q <= '0;
    else if (load) word_q <= din;
  end

  assign dout = word_q;
endmodule

// File: rtl/sst_done.sv
module sst_done (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= fire;
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/sst_word_tx.sv
module sst_word_tx
  import sst_pkg::*;
#(
  parameter int DW = SST_DW_DEFAULT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] usr_word,
  input  logic          usr_send,
  output logic          usr_done,
  output logic [DW-1:0] st_tdata,
  output logic          st_tvalid,
  output logic          st_tlast,
  input  logic          st_tready
);
  logic load;
  logic fire;

  sst_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .send  (usr_send),
    .ready (st_tready),
    .load  (load),
    .fire  (fire),
    .valid (st_tvalid),
    .last  (st_tlast)
  );

  sst_hold #(.DW(DW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .din   (usr_word),
    .dout  (st_tdata)
  );

  sst_done u_done (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .pulse (usr_done)
  );
endmodule

// File: rtl/sst_word_tx_chk.sv
module sst_word_tx_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] usr_word,
  input logic          usr_send,
  input logic          usr_done,
  input logic [DW-1:0] st_tdata,
  input logic          st_tvalid,
  input logic          st_tlast,
  input logic          st_tready
);
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!st_tvalid && !st_tlast && !usr_done && st_tdata == '0));

  a_r2_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_tvalid && usr_send) |=> (st_tvalid && st_tdata == $past(usr_word)));

  a_r3_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (st_tvalid && !st_tready) |=> (st_tvalid && st_tlast && $stable(st_tdata)));

  a_r4_drop_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (st_tvalid && st_tready && !usr_send) |=> (!st_tvalid && !st_tlast));

  a_r5_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (st_tvalid && st_tready) |=> usr_done);

  a_r5_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    usr_done |-> $past(st_tvalid && st_tready));

  a_r7_chain_load: assert property (@(posedge clk) disable iff (!rst_n)
    (st_tvalid && st_tready && usr_send) |=> (st_tvalid && st_tdata == $past(usr_word)));

  a_r9_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    st_tlast == st_tvalid);
endmodule

bind sst_word_tx sst_word_tx_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .usr_word  (usr_word),
  .usr_send  (usr_send),
  .usr_done  (usr_done),
  .st_tdata  (st_tdata),
  .st_tvalid (st_tvalid),
  .st_tlast  (st_tlast),
  .st_tready (st_tready)
);

// File: tb/sst_word_tx_tb.sv
`timescale 1ns/1ps
module sst_word_tx_tb;
  localparam int DW     = 32;
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] usr_word = '0;
  logic          usr_send = 1'b0;
  logic          usr_done;
  logic [DW-1:0] st_tdata;
  logic          st_tvalid;
  logic          st_tlast;
  logic          st_tready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sst_word_tx #(.DW(DW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .usr_word  (usr_word),
    .usr_send  (usr_send),
    .usr_done  (usr_done),
    .st_tdata  (st_tdata),
    .st_tvalid (st_tvalid),
    .st_tlast  (st_tlast),
    .st_tready (st_tready)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Checks the whole output set against an expected idle or busy state.
  task automatic chk_out(input string req, input bit v, input logic [DW-1:0] d, input bit dn);
    chk(st_tvalid == v, {req, " valid"}, DW'(st_tvalid), DW'(v));
    chk(st_tlast  == v, {req, " last (R9)"}, DW'(st_tlast), DW'(v));
    chk(usr_done  == dn, {req, " done"}, DW'(usr_done), DW'(dn));
    if (v) chk(st_tdata == d, {req, " data"}, st_tdata, d);
  endtask

  function automatic logic [DW-1:0] word_of(input int a, input int b);
    return DW'((a + 1) * 32'h9E37_79B9) ^ DW'((b + 3) * 32'h0101_0301);
  endfunction

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] w;
    logic [DW-1:0] w2;
    // R1: reset state
    rst_n = 1'b0;
    usr_word = '1;
    repeat (3) tick();
    chk(st_tdata == '0, "R1 data cleared", st_tdata, '0);
    chk_out("R1", 1'b0, '0, 1'b0);
    rst_n = 1'b1;
    tick();

    // R10: ready high while idle gives nothing
    st_tready = 1'b1;
    repeat (3) begin
      tick();
      chk_out("R10", 1'b0, '0, 1'b0);
    end
    st_tready = 1'b0;

    // Sweep: stall length x word pattern; odd patterns fire ignored strobes (R6)
    for (int stall = 0; stall < 7; stall++) begin
      for (int k = 0; k < 4; k++) begin
        w = word_of(stall, k);
        usr_word = w;
        usr_send = 1'b1;
        st_tready = 1'b0;
        tick();
        usr_send = 1'b0;
        usr_word = ~w;
        chk_out("R2 R8", 1'b1, w, 1'b0);
        for (int i = 0; i < stall; i++) begin
          usr_send = k[0];
          tick();
          usr_send = 1'b0;
          chk_out(k[0] ? "R6" : "R3", 1'b1, w, 1'b0);
        end
        st_tready = 1'b1;
        tick();
        st_tready = 1'b0;
        chk_out("R4 R5", 1'b0, '0, 1'b1);
        tick();
        chk_out("R5 R6 no extra", 1'b0, '0, 1'b0);
      end
    end

    // R7: send coinciding with acceptance
    w  = 32'h1357_9BDF;
    w2 = 32'h2468_ACE0;
    usr_word = w;
    usr_send = 1'b1;
    tick();
    chk_out("R7 first", 1'b1, w, 1'b0);
    usr_word = w2;
    st_tready = 1'b1;
    tick();
    usr_send = 1'b0;
    chk_out("R7 reload", 1'b1, w2, 1'b1);
    tick();
    st_tready = 1'b0;
    chk_out("R7 second accept", 1'b0, '0, 1'b1);
    tick();
    chk_out("R7 quiet", 1'b0, '0, 1'b0);

    // R1: reset while stalled
    usr_word = 32'hCAFE_F00D;
    usr_send = 1'b1;
    tick();
    usr_send = 1'b0;
    chk_out("R1 pre", 1'b1, 32'hCAFE_F00D, 1'b0);
    rst_n = 1'b0;
    tick();
    chk(st_tdata == '0, "R1 mid-transfer data", st_tdata, '0);
    chk_out("R1 mid-transfer", 1'b0, '0, 1'b0);
    rst_n = 1'b1;
    st_tready = 1'b1;
    tick();
    chk_out("R1 R10 after reset", 1'b0, '0, 1'b0);
    st_tready = 1'b0;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule